// File: doc/BRIEF.md
# Floating-Point Condition Compare Unit

This unit evaluates one relational predicate over two single-precision IEEE-754 operands and latches the one-bit outcome into a branch-condition register. The operands sit in an external 32-entry by 32-bit register file. The unit drives the file's two read addresses straight from the instruction's operand indices and takes the returned words in the same cycle.

A 4-bit condition code selects the predicate. Its low three bits choose one of eight predicates that are aware of unordered results. Its top bit chooses between a quiet form and a signalling form. The signalling form raises a sticky invalid-operation flag whenever the comparison is unordered. The flag stays set until software clears it through a clear strobe.

Top module: `fpcc_unit`

## Requirements
- R1: While reset is asserted and after its release, the condition output and the invalid flag are both 0 until the first strobed compare.
- R2: Condition codes whose low three bits are 000 (codes 0 and 8) always produce a condition of 0, whatever the operands.
- R3: Low bits 001 give 1 only when the comparison is unordered. A comparison is unordered when either operand is a NaN. A NaN has all exponent bits (30:23) set and a nonzero fraction (22:0).
- R4: Low bits 010 give 1 when the operands are equal. Low bits 011 give 1 when they are equal or unordered.
- R5: Each ordered pair of operands is exactly one of less, equal or greater, using sign-and-magnitude ordering. The predicates are: 100 is less, 101 is less or unordered, 110 is less or equal, 111 is not greater.
- R6: Positive zero and negative zero compare equal.
- R7: A quiet code (bit 3 = 0) with quiet NaN operands leaves the invalid flag unchanged. A quiet NaN has fraction bit 22 set.
- R8: A signalling code (bit 3 = 1) sets the invalid flag when the comparison is unordered. It leaves the flag unchanged when the comparison is ordered.
- R9: A signalling NaN operand sets the invalid flag under any code. A signalling NaN is a NaN with fraction bit 22 clear.
- R10: The invalid flag holds until `flag_clr` is strobed, and it reads 0 in the cycle after the clear. If a flag-raising compare arrives in the same cycle as the clear, the set wins.
- R11: The condition output changes only in the cycle after a strobe of `op_valid`, and it holds its value otherwise.
- R12: The register-file read addresses equal the operand indices `src_a_idx` and `src_b_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Compare instruction strobe |
| cond_code | input | 4 | Predicate select; bit 3 chooses the signalling form |
| src_a_idx | input | 5 | Index of the first operand |
| src_b_idx | input | 5 | Index of the second operand |
| rf_raddr_a | output | 5 | Register-file read address, first operand |
| rf_raddr_b | output | 5 | Register-file read address, second operand |
| rf_rdata_a | input | 32 | Register-file read data, first operand |
| rf_rdata_b | input | 32 | Register-file read data, second operand |
| flag_clr | input | 1 | Software clear of the invalid flag |
| bcond_o | output | 1 | Branch-condition register |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
Ten operand pairs are each run through all sixteen codes. The ordered finite pairs (less, greater, equal, and negatives of mixed sign) separate the less, equal and greater paths. The pair of opposite-signed zeros exposes sign-sensitive equality. The two infinities confirm that the top of the exponent range is still ordered when the fraction is zero. Pairs with a quiet NaN separate the quiet and signalling forms through the flag, and a pair with a signalling NaN shows that even quiet codes raise the flag. Separate sequences cover clearing the flag, a set and a clear in the same cycle, and idle cycles that must hold both outputs.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int CC_W   = 4;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic            nan;
    logic            snan;
    logic            zero;
    logic            sign;
    logic [FP_W-2:0] mag;
  } fp_class_t;

  typedef struct packed {
    logic un;
    logic lt;
    logic eq;
    logic gt;
  } fp_rel_t;
endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output fp_class_t       cls_o
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_full;

  always_comb begin
    expo          = val_i[FP_W-2 -: EXP_W];
    frac          = val_i[FRAC_W-1:0];
    exp_full      = &expo;
    cls_o.nan     = exp_full & (|frac);
    cls_o.snan    = exp_full & (|frac) & ~frac[FRAC_W-1];
    cls_o.zero    = ~(|val_i[FP_W-2:0]);
    cls_o.sign    = val_i[FP_W-1];
    cls_o.mag     = val_i[FP_W-2:0];
  end
endmodule

// File: rtl/fpcc_relate.sv
module fpcc_relate
  import fpcc_pkg::*;
(
  input  fp_class_t a_i,
  input  fp_class_t b_i,
  output fp_rel_t   rel_o
);
  logic unord;
  logic same_val;
  logic a_below;

  always_comb begin
    unord    = a_i.nan | b_i.nan;
    same_val = (a_i.zero & b_i.zero) |
               ((a_i.sign == b_i.sign) && (a_i.mag == b_i.mag));
    if (a_i.sign != b_i.sign)
      a_below = a_i.sign;
    else if (a_i.sign)
      a_below = (a_i.mag > b_i.mag);
    else
      a_below = (a_i.mag < b_i.mag);

    rel_o.un = unord;
    rel_o.eq = ~unord & same_val;
    rel_o.lt = ~unord & ~same_val & a_below;
    rel_o.gt = ~unord & ~same_val & ~a_below;
  end

  // R5
  always_comb begin
    relation_onehot_chk: assert ($onehot({rel_o.un, rel_o.lt, rel_o.eq, rel_o.gt}));
  end
endmodule

// File: rtl/fpcc_predicate.sv
module fpcc_predicate
  import fpcc_pkg::*;
(
  input  logic [CC_W-1:0] cc_i,
  input  fp_rel_t         rel_i,
  input  logic            any_snan_i,
  output logic            hit_o,
  output logic            raise_o
);
  logic trap_form;

  always_comb begin
    trap_form = cc_i[CC_W-1];
    hit_o     = (cc_i[0] & rel_i.un) |
                (cc_i[1] & rel_i.eq) |
                (cc_i[2] & rel_i.lt);
    raise_o   = any_snan_i | (trap_form & rel_i.un);
  end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       cond_code,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  output logic [IDX_W-1:0] rf_raddr_a,
  output logic [IDX_W-1:0] rf_raddr_b,
  input  logic [31:0]      rf_rdata_a,
  input  logic [31:0]      rf_rdata_b,
  input  logic             flag_clr,
  output logic             bcond_o,
  output logic             invalid_o
);
  logic [FP_W-1:0] opnd [NUM_SRC];
  fp_class_t       cls  [NUM_SRC];
  fp_rel_t         rel;
  logic            hit;
  logic            raise;
  logic            any_snan;

  logic bcond_q, bcond_d, bcond_en;
  logic inv_q, inv_d, inv_en;

  assign rf_raddr_a = src_a_idx;
  assign rf_raddr_b = src_b_idx;
  assign opnd[0]    = rf_rdata_a;
  assign opnd[1]    = rf_rdata_b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
    fpcc_classify u_cls (
      .val_i (opnd[g]),
      .cls_o (cls[g])
    );
  end

  assign any_snan = cls[0].snan | cls[1].snan;

  fpcc_relate u_rel (
    .a_i   (cls[0]),
    .b_i   (cls[1]),
    .rel_o (rel)
  );

  fpcc_predicate u_pred (
    .cc_i       (cond_code),
    .rel_i      (rel),
    .any_snan_i (any_snan),
    .hit_o      (hit),
    .raise_o    (raise)
  );

  // next-state logic
  always_comb begin
    bcond_en = op_valid;
    bcond_d  = hit;
    inv_en   = (op_valid & raise) | flag_clr;
    inv_d    = op_valid & raise;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcond_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      if (bcond_en) bcond_q <= bcond_d;
      if (inv_en)   inv_q   <= inv_d;
    end
  end

  assign bcond_o   = bcond_q;
  assign invalid_o = inv_q;

  // R2
  false_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_code[2:0] == 3'b000) |=> !bcond_o);

  // R11
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(bcond_o));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_o && !flag_clr) |=> invalid_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !op_valid) |=> !invalid_o);

  // R12
  raddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr_a == src_a_idx) && (rf_raddr_b == src_b_idx));
endmodule

// File: tb/fpcc_unit_test.sv
module fpcc_unit_test;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] cond_code;
  logic [4:0] src_a_idx, src_b_idx;
  logic [4:0] rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b;
  logic       flag_clr;
  logic       bcond_o, invalid_o;

  logic [31:0] rf [32];
  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];

  fpcc_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_code(cond_code),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .flag_clr(flag_clr), .bcond_o(bcond_o), .invalid_o(invalid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic  c;
    logic  f;
    string tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int fails  = 0;
  int slot   = 0;
  logic exp_c = 1'b0;
  logic exp_f = 1'b0;
  bit   done  = 0;

  function automatic logic is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic logic is_snan(logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction

  function automatic logic signed [32:0] okey(logic [31:0] v);
    logic signed [32:0] m;
    m = {2'b00, v[30:0]};
    if (v[30:0] == 0) return 0;
    return v[31] ? -m : m;
  endfunction

  task automatic check(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [3:0] cc, logic [31:0] a, logic [31:0] b,
                      logic clr, string tag);
    logic un, lt, eq, hit, rs;
    int ia, ib;
    item_t it;
    @(negedge clk);
    ia = slot % 32;
    ib = (slot + 17) % 32;
    slot++;
    rf[ia] = a;
    rf[ib] = b;
    op_valid  = v;
    cond_code = cc;
    src_a_idx = 5'(ia);
    src_b_idx = 5'(ib);
    flag_clr  = clr;
    un  = is_nan(a) || is_nan(b);
    eq  = !un && (okey(a) == okey(b));
    lt  = !un && (okey(a) < okey(b));
    hit = (cc[0] && un) || (cc[1] && eq) || (cc[2] && lt);
    rs  = is_snan(a) || is_snan(b) || (cc[3] && un);
    if (v) exp_c = hit;
    if (v && rs) exp_f = 1'b1;
    else if (clr) exp_f = 1'b0;
    it.c = exp_c; it.f = exp_f; it.tag = tag;
    sb.push_back(it);
    #1;
    checks++;
    if (rf_raddr_a !== src_a_idx || rf_raddr_b !== src_b_idx) begin
      fails++;
      $display("FAIL R12 raddr: actual %0d/%0d expected %0d/%0d",
               rf_raddr_a, rf_raddr_b, ia, ib);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(bcond_o, it.c, it.tag, "condition");
        check(invalid_o, it.f, it.tag, "invalid flag");
      end
    end
  end

  function automatic string tag_for(logic [3:0] cc, logic [31:0] a, logic [31:0] b,
                                    string base);
    if (cc[2:0] == 3'b000) return "R2";
    if (is_snan(a) || is_snan(b)) return "R9";
    if (cc[2:0] == 3'b001) return "R3";
    if ((is_nan(a) || is_nan(b)) && cc[3]) return "R8";
    if (is_nan(a) || is_nan(b)) return "R7";
    return base;
  endfunction

  logic [31:0] pa [10] = '{32'h3F800000, 32'h40000000, 32'h3FC00000, 32'h00000000,
                           32'hC0400000, 32'hBF800000, 32'h7FC00000, 32'h3F800000,
                           32'h7F800000, 32'hFF800000};
  logic [31:0] pb [10] = '{32'h40000000, 32'h3F800000, 32'h3FC00000, 32'h80000000,
                           32'hBF800000, 32'h40000000, 32'h3F800000, 32'h7F800001,
                           32'hFF800000, 32'h7FC00000};
  string pt [10] = '{"R5", "R5", "R4", "R6", "R5", "R5", "R7", "R9", "R5", "R8"};

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0;
    rst_n = 1'b0; op_valid = 1'b0; cond_code = 4'h0; flag_clr = 1'b0;
    src_a_idx = 5'd0; src_b_idx = 5'd0;
    repeat (3) @(negedge clk);
    check(bcond_o, 1'b0, "R1", "reset condition");
    check(invalid_o, 1'b0, "R1", "reset flag");
    rst_n = 1'b1;
    @(negedge clk);
    check(bcond_o, 1'b0, "R1", "post-reset condition");
    check(invalid_o, 1'b0, "R1", "post-reset flag");

    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 16; c++)
        step(1'b1, 4'(c), pa[p], pb[p], 1'b0, tag_for(4'(c), pa[p], pb[p], pt[p]));
      step(1'b0, 4'h0, 32'h0, 32'h0, 1'b1, "R10");
    end

    // R11: idle cycles hold the last condition
    step(1'b1, 4'h4, 32'h3F800000, 32'h40000000, 1'b0, "R5");
    step(1'b0, 4'h0, 32'h7FC00000, 32'h7F800001, 1'b0, "R11");
    step(1'b0, 4'h2, 32'h0, 32'h0, 1'b0, "R11");
    // R10: sticky, set over clear, clear alone
    step(1'b1, 4'hB, 32'h7FC00000, 32'h0, 1'b0, "R8");
    step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, "R10");
    step(1'b1, 4'h2, 32'h3F800000, 32'h3F800000, 1'b0, "R10");
    step(1'b1, 4'h9, 32'h7FC00000, 32'h0, 1'b1, "R10");
    step(1'b0, 4'h0, 32'h0, 32'h0, 1'b1, "R10");
    step(1'b1, 4'hE, 32'h3F800000, 32'h40000000, 1'b1, "R8");
    step(1'b1, 4'h3, 32'h7FC00000, 32'h7FC00000, 1'b0, "R7");
    step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule